// File: doc/BRIEF.md
# Register-Controlled Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes, or 9-bit words, that software reads through a small byte-wide register bus. A baud generator is set by an 8-bit divisor and a fast/slow prescale select. It drives a 16x oversampling frame decoder. The decoder takes a three-sample majority vote at the middle of every bit. Each finished frame goes into a two-entry receive buffer, together with its ninth bit and a framing-error mark.

Software sets the divisor and the prescale, clears the mode bit, and then sets the port enable and the continuous-receive enable. When the buffer holds a frame, a receive-ready flag is set. The interrupt output follows that flag while the interrupt enable is set. Software first reads the status register, which gives the ninth bit and the error bits of the frame at the head of the buffer. It then reads the data register, and that read removes the frame from the buffer. If a frame completes while both buffer entries are full, the block latches an overrun and stops receiving. Turning continuous receive off clears all error state, and turning it on again resumes reception.

Top module: `serial_rx_regs`

## Requirements
- R1: After reset the control/status register (address 0) reads 0 in bits 7..1, the mode register (address 3) reads 0x00, the divisor register (address 2) reads 0x00 and the interrupt register (address 4) reads 0x00.
- R2: The oversampling tick period is N+1 clocks when mode bit 2 (fast) is 1 and 4×(N+1) clocks when it is 0, where N is the divisor. A bit lasts 16 ticks, and frames sent at that bit time are received correctly in both settings.
- R3: A frame is received only when control bit 7 (port enable) is 1, control bit 4 (continuous receive) is 1 and mode bit 4 (sync mode) is 0. In any other setting a frame leaves interrupt register bit 1 at 0.
- R4: Frames are an idle-high line, one low start bit, data sent LSB first, and one stop bit. In 8-bit mode (control bit 6 = 0) the data register (address 1) returns the 8 data bits, and status bit 0 reads 0.
- R5: With control bit 6 = 1, each frame carries a ninth data bit after the eight data bits, and status bit 0 of that frame shows it.
- R6: A stop bit sampled low sets status bit 2 (framing error) for that frame, and the data bits of that frame are still delivered.
- R7: A frame that completes while two unread frames are held sets status bit 1 (overrun). That frame is dropped, the two held frames stay readable in order, and no further frame is accepted while overrun is set.
- R8: Writing control bit 4 to 0 clears the overrun bit and the framing-error bits of held frames. Writing it back to 1 resumes reception.
- R9: Interrupt register bit 1 (receive ready, read-only) is 1 while the buffer holds a frame, and it returns to 0 once reads of the data register have emptied the buffer. The irq output equals bit 1 AND interrupt register bit 0 (enable).
- R10: A disturbance one tick long near the middle of a bit does not change the received value, because of the majority of three mid-bit samples.
- R11: Status bits 7..4 read back the written control bits, and status bit 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of address 1 pops the buffer |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is overrun. Three frames must arrive with no data read in between. The bench then has to show that the third frame was dropped, that a fourth frame sent while overrun is set is also ignored, and that clearing and setting continuous receive restores normal operation. A directed sequence reaches this state without reading the data register. It confirms the two held frames in order, sends a fourth frame to show the blocking, toggles continuous receive and then sends a fresh frame. The single-tick glitches for the majority vote are placed at the bit centres by the serial driver itself, and random frames mix widths, rates and glitches.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
   localparam int SRX_DW = 8;
   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_DATA = 3'd1;
   localparam logic [2:0] A_DIV  = 3'd2;
   localparam logic [2:0] A_MODE = 3'd3;
   localparam logic [2:0] A_IRQ  = 3'd4;

   typedef struct packed {
      logic              ferr;
      logic [SRX_DW:0]   word;
   } srx_entry_t;

   typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} srx_state_t;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
   parameter int DIV_W    = 8,
   parameter int SLOW_PRE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   input  logic             fast,
   output logic             tick
);
   localparam int PW = (SLOW_PRE > 1) ? $clog2(SLOW_PRE) : 1;

   if (SLOW_PRE < 2) begin : g_bad_pre
      $error("SLOW_PRE must be at least 2");
   end

   logic [DIV_W-1:0] cnt;
   logic [PW-1:0]    pre;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         pre  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (cnt >= divisor) begin
            cnt <= '0;
            if (fast) begin
               pre  <= '0;
               tick <= 1'b1;
            end else if (pre == PW'(SLOW_PRE - 1)) begin
               pre  <= '0;
               tick <= 1'b1;
            end else begin
               pre <= pre + 1'b1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(pre) < SLOW_PRE); // R2
endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import serial_rx_pkg::*;
#(
   parameter int OVS      = 16,
   parameter int MAJORITY = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            tick,
   input  logic            rx,
   input  logic            nine,
   output logic            done,
   output logic            ferr,
   output logic [SRX_DW:0] dout
);
   localparam int CW  = $clog2(OVS);
   localparam int MID = OVS / 2;
   localparam int DEC = (MAJORITY != 0) ? MID + 1 : MID;

   if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 8");
   end

   srx_state_t      state;
   logic [CW-1:0]   phase;
   logic [3:0]      idx;
   logic            s_a, s_b, nine_l, bit_val;
   logic [SRX_DW:0] shreg;

   if (MAJORITY != 0) begin : g_vote
      assign bit_val = vote3(s_a, s_b, rx);
   end else begin : g_single
      assign bit_val = rx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         phase  <= '0;
         idx    <= '0;
         s_a    <= 1'b1;
         s_b    <= 1'b1;
         nine_l <= 1'b0;
         shreg  <= '0;
         done   <= 1'b0;
         ferr   <= 1'b0;
         dout   <= '0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            state <= S_IDLE;
            phase <= '0;
         end else if (tick) begin
            if (state == S_IDLE) begin
               if (!rx) begin
                  state  <= S_START;
                  phase  <= CW'(1);
                  nine_l <= nine;
                  shreg  <= '0;
               end
            end else begin
               phase <= phase + 1'b1;
               if (phase == CW'(MID - 1)) s_a <= rx;
               if (phase == CW'(MID))     s_b <= rx;
               if (phase == CW'(DEC)) begin
                  case (state)
                     S_START: if (bit_val) state <= S_IDLE;
                     S_DATA:  shreg[idx] <= bit_val;
                     S_STOP: begin
                        done  <= 1'b1;
                        ferr  <= !bit_val;
                        dout  <= shreg;
                        state <= S_IDLE;
                     end
                     default: ;
                  endcase
               end
               if (phase == CW'(OVS - 1)) begin
                  if (state == S_START) begin
                     state <= S_DATA;
                     idx   <= '0;
                  end else if (state == S_DATA) begin
                     if (idx == (nine_l ? 4'd8 : 4'd7)) state <= S_STOP;
                     else idx <= idx + 1'b1;
                  end
               end
            end
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= 4'd8); // R5
   AST_EIGHT_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      done && !nine_l |-> !dout[SRX_DW]); // R4
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
   import serial_rx_pkg::*;
#(
   parameter int DEPTH = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  logic       pop,
   input  logic       clr_err,
   input  srx_entry_t din,
   output srx_entry_t head,
   output logic       full,
   output logic       empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   srx_entry_t    mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] count;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign head  = mem[rp];

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (clr_err)
            for (int i = 0; i < DEPTH; i++) mem[i].ferr <= 1'b0;
         if (push && !full) begin
            mem[wp] <= din;
            wp      <= bump(wp);
         end
         if (pop && !empty) rp <= bump(rp);
         count <= count + CW'(push && !full) - CW'(pop && !empty);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      32'(count) <= DEPTH); // R7
   AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      full && !pop |=> full); // R7
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
   import serial_rx_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int SLOW_PRE = 4,
   parameter int OVS      = 16,
   parameter int DEPTH    = 2,
   parameter int MAJORITY = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [2:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       irq
);
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must be 1..8");
   end

   logic             spen, rx9, sren, cren, sync_m, fast, ie, oerr;
   logic [DIV_W-1:0] divisor;
   logic             rx_m, rx_s, tick, en, done, fr_ferr, pop, full, empty;
   logic [SRX_DW:0]  fr_word;
   srx_entry_t       head;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_m <= 1'b1;
         rx_s <= 1'b1;
      end else begin
         rx_m <= rx;
         rx_s <= rx_m;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {spen, rx9, sren, cren} <= 4'b0;
         {sync_m, fast, ie}      <= 3'b0;
         divisor                 <= '0;
         oerr                    <= 1'b0;
      end else begin
         if (wr_en) begin
            case (addr)
               A_CTRL: {spen, rx9, sren, cren} <= wdata[7:4];
               A_DIV:  divisor <= wdata[DIV_W-1:0];
               A_MODE: {sync_m, fast} <= {wdata[4], wdata[2]};
               A_IRQ:  ie <= wdata[0];
               default: ;
            endcase
         end
         if (!cren) oerr <= 1'b0;
         else if (done && full) oerr <= 1'b1;
      end
   end

   assign en  = spen && !sync_m && cren && !oerr;
   assign pop = rd_en && (addr == A_DATA);
   assign irq = ie && !empty;

   always_comb begin
      case (addr)
         A_CTRL:  rdata = {spen, rx9, sren, cren, 1'b0, head.ferr & !empty, oerr, head.word[SRX_DW]};
         A_DATA:  rdata = head.word[SRX_DW-1:0];
         A_DIV:   rdata = 8'(divisor);
         A_MODE:  rdata = {3'b0, sync_m, 1'b0, fast, 2'b0};
         A_IRQ:   rdata = {6'b0, !empty, ie};
         default: rdata = 8'h00;
      endcase
   end

   srx_baud #(.DIV_W(DIV_W), .SLOW_PRE(SLOW_PRE)) u_baud (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .fast(fast), .tick(tick));

   srx_frame #(.OVS(OVS), .MAJORITY(MAJORITY)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .rx(rx_s), .nine(rx9),
      .done(done), .ferr(fr_ferr), .dout(fr_word));

   srx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(done), .pop(pop), .clr_err(!cren),
      .din('{ferr: fr_ferr, word: fr_word}), .head(head), .full(full), .empty(empty));

   AST_OERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oerr) && $past(cren) && cren |-> oerr); // R7
   AST_OERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oerr) |-> !done); // R7
   AST_CREN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cren) |-> !oerr); // R8
   AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(empty) |-> $past(pop)); // R9
endmodule

// File: tb/tb_serial_rx_regs.sv
module tb_serial_rx_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq;

   int n_chk = 0, n_bad = 0, cyc = 0;
   int bclk = 64;
   bit finished = 0;

   serial_rx_regs dut (.clk(clk), .rst_n(rst_n), .rx(rx), .wr_en(wr_en), .rd_en(rd_en),
                       .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000 && !finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got %0d cycles expected < 190000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk); addr = a; #1 v = rdata;
   endtask

   task automatic pop(output logic [7:0] v);
      @(negedge clk); addr = 3'd1; rd_en = 1'b1; #1 v = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   function automatic logic [7:0] exp_stat(input logic [7:0] ctrl, input logic fe,
                                           input logic oe, input logic b9);
      return {ctrl[7:4], 1'b0, fe, oe, b9};
   endfunction

   task automatic drive_bit(input logic v, input bit glitch);
      int t = bclk / 16;
      for (int k = 0; k < bclk; k++) begin
         @(negedge clk);
         rx = (glitch && k >= bclk / 2 - t / 2 && k < bclk / 2 - t / 2 + t) ? ~v : v;
      end
   endtask

   task automatic send(input logic [8:0] w, input bit nine, input bit stop_hi, input bit glitch);
      drive_bit(1'b0, 1'b0);
      for (int i = 0; i < (nine ? 9 : 8); i++) drive_bit(w[i], glitch);
      drive_bit(stop_hi, 1'b0);
      @(negedge clk); rx = 1'b1;
      repeat (bclk) @(negedge clk);
   endtask

   logic [7:0] v, ctrl;

   task automatic expect_frame(input string tag, input logic [7:0] c, input logic [8:0] w,
                               input bit nine, input bit fe);
      rd(3'd0, v); check({tag, " status"}, v, exp_stat(c, fe, 1'b0, nine ? w[8] : 1'b0));
      pop(v);      check({tag, " data"}, v, w[7:0]);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(3'd0, v); check("R1 ctrl", v & 8'hFE, 8'h00);
      rd(3'd3, v); check("R1 mode", v, 8'h00);
      rd(3'd2, v); check("R1 div", v, 8'h00);
      rd(3'd4, v); check("R1 irq reg", v, 8'h00);
      check("R1 irq pin", {7'b0, irq}, 8'h00);

      wr(3'd2, 8'd3); wr(3'd3, 8'h04); wr(3'd4, 8'h01); bclk = 64;
      // R3 disabled receive
      wr(3'd0, 8'h80); send(9'h05A, 0, 1, 0);
      rd(3'd4, v); check("R3 cren off", v, 8'h01);
      wr(3'd3, 8'h14); wr(3'd0, 8'h90); send(9'h05A, 0, 1, 0);
      rd(3'd4, v); check("R3 sync mode", v, 8'h01);
      wr(3'd0, 8'h10); wr(3'd3, 8'h04); send(9'h05A, 0, 1, 0);
      rd(3'd4, v); check("R3 spen off", v, 8'h01);

      // R4 / R9 / R11
      ctrl = 8'hB0; wr(3'd0, ctrl); send(9'h0A5, 0, 1, 0);
      rd(3'd4, v); check("R9 ready", v, 8'h03);
      check("R9 irq pin", {7'b0, irq}, 8'h01);
      rd(3'd0, v); check("R11 ctrl readback", v, 8'hB0);
      ctrl = 8'h90; wr(3'd0, ctrl);
      pop(v); check("R4 data", v, 8'hA5);
      rd(3'd4, v); check("R9 empty", v, 8'h01);
      check("R9 irq low", {7'b0, irq}, 8'h00);
      wr(3'd4, 8'h00); send(9'h03C, 0, 1, 0);
      check("R9 masked irq", {7'b0, irq}, 8'h00);
      rd(3'd4, v); check("R9 masked ready", v, 8'h02);
      expect_frame("R4 masked", ctrl, 9'h03C, 0, 0);
      wr(3'd4, 8'h01);

      // R5 nine-bit
      ctrl = 8'hD0; wr(3'd0, ctrl);
      send(9'h13C, 1, 1, 0); expect_frame("R5 b9=1", ctrl, 9'h13C, 1, 0);
      send(9'h0C3, 1, 1, 0); expect_frame("R5 b9=0", ctrl, 9'h0C3, 1, 0);

      // R2 slow prescale
      ctrl = 8'h90; wr(3'd0, ctrl); wr(3'd2, 8'd1); wr(3'd3, 8'h00); bclk = 128;
      send(9'h096, 0, 1, 0); expect_frame("R2 slow", ctrl, 9'h096, 0, 0);
      wr(3'd2, 8'd7); wr(3'd3, 8'h04); bclk = 128;
      send(9'h069, 0, 1, 0); expect_frame("R2 fast div7", ctrl, 9'h069, 0, 0);
      wr(3'd2, 8'd3); bclk = 64;

      // R10 glitch
      send(9'h0F0, 0, 1, 1); expect_frame("R10 glitch", ctrl, 9'h0F0, 0, 0);
      send(9'h00F, 0, 1, 1); expect_frame("R10 glitch2", ctrl, 9'h00F, 0, 0);

      // R6 framing error, R8 clears it
      send(9'h0E1, 0, 0, 0);
      rd(3'd0, v); check("R6 ferr", v, exp_stat(ctrl, 1, 0, 0));
      wr(3'd0, 8'h80);
      rd(3'd0, v); check("R8 ferr cleared", v, 8'h80);
      pop(v); check("R6 data", v, 8'hE1);
      wr(3'd0, ctrl);

      // R7 overrun
      send(9'h011, 0, 1, 0); send(9'h022, 0, 1, 0); send(9'h033, 0, 1, 0);
      rd(3'd0, v); check("R7 overrun", v, exp_stat(ctrl, 0, 1, 0));
      pop(v); check("R7 first", v, 8'h11);
      pop(v); check("R7 second", v, 8'h22);
      rd(3'd4, v); check("R7 third dropped", v, 8'h01);
      send(9'h044, 0, 1, 0);
      rd(3'd4, v); check("R7 blocked", v, 8'h01);
      rd(3'd0, v); check("R7 still set", v, exp_stat(ctrl, 0, 1, 0));
      wr(3'd0, 8'h80); wr(3'd0, ctrl);
      rd(3'd0, v); check("R8 oerr cleared", v, exp_stat(ctrl, 0, 0, 0));
      send(9'h055, 0, 1, 0); expect_frame("R8 resumed", ctrl, 9'h055, 0, 0);

      // random frames
      void'($urandom(32'h5EED_1234));
      for (int n = 0; n < 30; n++) begin
         logic [8:0] w = 9'($urandom);
         bit nine = 1'($urandom);
         bit slow = 1'($urandom);
         bit gl = 1'($urandom);
         ctrl = nine ? 8'hD0 : 8'h90;
         wr(3'd0, ctrl);
         if (slow) begin wr(3'd2, 8'd1); wr(3'd3, 8'h00); bclk = 128; end
         else      begin wr(3'd2, 8'd3); wr(3'd3, 8'h04); bclk = 64; end
         send(w, nine, 1, gl);
         expect_frame(nine ? "R5 random" : "R4 random", ctrl, w, nine, 0);
      end

      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule